// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This block sits between a 32-bit load-store core and a word-wide data memory whose bytes are numbered big-endian: the byte at the lowest address of a word is its most significant byte. For each request it forms the effective address from a base register and a sign-extended 16-bit byte offset. It registers a word-aligned memory address. For stores it also registers a per-byte write enable vector and write data shifted into the addressed lanes.

A request whose address is not a multiple of its access size is not sent to memory. In that case a one-cycle misalignment pulse is raised instead. The offset, size and signedness of the last request are held in the unit. When memory returns the word in the cycle after the request, the unit picks the addressed byte or halfword from it and widens it to 32 bits, with sign or zero extension.

Top module: `lsu_lane_unit`

## Requirements
- R1: One clock after a request, `mem_addr` equals `base_addr` plus `offset` sign-extended to 32 bits, with bits 1:0 forced to zero.
- R2: Size code 00 is byte, 01 is halfword and 10 is word. `byte_en` bit 3 covers address offset 0 and bit 0 covers offset 3. An aligned store drives one bit for a byte, 1100 or 0011 for a halfword at offset 0 or 2, and 1111 for a word. A load drives 0000.
- R3: Store data comes from the low end of `st_data`. Byte data at offset k sits in bits [31-8k:24-8k]. A halfword at offset 0 sits in bits 31:16 and at offset 2 in bits 15:0. A word passes through unchanged. Unwritten lanes are zero.
- R4: A halfword at an odd address, or a word at an address whose bits 1:0 are not zero, raises `misalign` for exactly one cycle. In that cycle `mem_req` and all byte enables are low. A byte access is never misaligned.
- R5: For a byte load, `ld_data` holds the addressed byte of `mem_rdata`. It is sign-extended when `req_unsigned` was 0 and zero-extended when it was 1.
- R6: For a halfword load, `ld_data` holds bits 31:16 or 15:0 of `mem_rdata` for offset 0 or 2, extended the same way.
- R7: For a word load, `ld_data` equals `mem_rdata` in all 32 bits, whatever `req_unsigned` is.
- R8: A cycle without `req_valid` yields `mem_req`, `misalign` and `byte_en` all low on the next cycle.
- R9: While reset is asserted, `mem_req`, `mem_store`, `misalign`, `byte_en`, `mem_addr` and `mem_wdata` are zero.
- R10: Size code 11 behaves exactly as a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half, 10/11 word |
| req_unsigned | input | 1 | Load zero-extends when 1 |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed byte displacement |
| st_data | input | 32 | Store source register |
| mem_rdata | input | 32 | Word returned by memory the cycle after a request |
| mem_req | output | 1 | Aligned access issued to memory |
| mem_store | output | 1 | Issued access is a store |
| mem_addr | output | 32 | Word-aligned address |
| byte_en | output | 4 | Byte write enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-positioned store data |
| misalign | output | 1 | One-cycle misaligned-access pulse |
| ld_data | output | 32 | Extended load result |

## Verification
On every cycle, the assertions check several properties of the outputs. The address is always word-aligned. A misalignment pulse never coincides with an issued access or any active enable, and it follows a request. The enable vector only takes the legal lane shapes, and it is active only for issued stores. An idle cycle leaves the outputs quiet on the next cycle. Some behaviour can only be shown by the bench scenarios, because it depends on the data values: whether the right lane was picked, whether extension used the right sign bit, and whether the sign-extended offset carried into the upper address bits.

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic          req_unsigned,
  input  logic [AW-1:0] base_addr,
  input  logic [OW-1:0] offset,
  input  logic [DW-1:0] st_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_store,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    byte_en,
  output logic [DW-1:0] mem_wdata,
  output logic          misalign,
  output logic [DW-1:0] ld_data
);

  logic [AW-1:0] ea;
  logic [1:0]    lo;
  logic          is_half, is_word, bad;
  logic [3:0]    lanes;
  logic [DW-1:0] placed;
  logic [1:0]    h_lo;
  logic          h_half, h_word, h_uns;
  logic [7:0]    pick_b;
  logic [15:0]   pick_h;

  assign ea      = base_addr + {{(AW-OW){offset[OW-1]}}, offset};
  assign lo      = ea[1:0];
  assign is_word = req_size[1];
  assign is_half = (req_size == 2'b01);
  assign bad     = (is_half & lo[0]) | (is_word & (lo != 2'b00));

  always_comb begin
    if (is_word)      lanes = 4'b1111;
    else if (is_half) lanes = lo[1] ? 4'b0011 : 4'b1100;
    else              lanes = 4'b1000 >> lo;
  end

  always_comb begin
    if (is_word)      placed = st_data;
    else if (is_half) placed = lo[1] ? {16'h0, st_data[15:0]} : {st_data[15:0], 16'h0};
    else              placed = {24'h0, st_data[7:0]} << (8 * (3 - lo));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_store <= 1'b0;
      mem_addr  <= '0;
      byte_en   <= 4'b0;
      mem_wdata <= '0;
      misalign  <= 1'b0;
      h_lo      <= 2'b0;
      h_half    <= 1'b0;
      h_word    <= 1'b0;
      h_uns     <= 1'b0;
    end else begin
      mem_req   <= req_valid & ~bad;
      mem_store <= req_valid & ~bad & req_store;
      misalign  <= req_valid & bad;
      byte_en   <= (req_valid & ~bad & req_store) ? lanes : 4'b0;
      if (req_valid) begin
        mem_addr  <= {ea[AW-1:2], 2'b00};
        mem_wdata <= req_store ? placed : '0;
        h_lo      <= lo;
        h_half    <= is_half;
        h_word    <= is_word;
        h_uns     <= req_unsigned;
      end
    end
  end

  assign pick_b = 8'(mem_rdata >> (8 * (3 - h_lo)));
  assign pick_h = h_lo[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    if (h_word)      ld_data = mem_rdata;
    else if (h_half) ld_data = {{16{~h_uns & pick_h[15]}}, pick_h};
    else             ld_data = {{24{~h_uns & pick_b[7]}}, pick_b};
  end

endmodule

// File: rtl/lsu_lane_chk.sv
module lsu_lane_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        mem_req,
  input logic        mem_store,
  input logic [31:0] mem_addr,
  input logic [3:0]  byte_en,
  input logic        misalign
);

  assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[1:0] == 2'b00);

  assert_en_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_en inside {4'b0000, 4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b1100, 4'b0011, 4'b1111});

  assert_en_only_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en != 4'b0) |-> (mem_req && mem_store));

  assert_misalign_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_req && byte_en == 4'b0));

  assert_misalign_from_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> $past(req_valid));

  assert_idle_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_req && !misalign && byte_en == 4'b0));

endmodule

bind lsu_lane_unit lsu_lane_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .mem_req   (mem_req),
  .mem_store (mem_store),
  .mem_addr  (mem_addr),
  .byte_en   (byte_en),
  .misalign  (misalign)
);

// File: tb/tb_lsu_lane_unit.sv
module tb_lsu_lane_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_store = 0, req_unsigned = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] base_addr = 0, st_data = 0, mem_rdata = 0;
  logic [15:0] offset = 0;
  logic        mem_req, mem_store, misalign;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  byte_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lsu_lane_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base_addr(base_addr),
    .offset(offset), .st_data(st_data), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_store(mem_store), .mem_addr(mem_addr),
    .byte_en(byte_en), .mem_wdata(mem_wdata), .misalign(misalign), .ld_data(ld_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_ea(input logic [31:0] b, input logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  function automatic logic f_bad(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'b00) return 1'b0;
    if (sz == 2'b01) return lo[0];
    return lo != 2'b00;
  endfunction

  function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'b00: return 4'(1 << (3 - lo));
      2'b01: return (lo == 2'b00) ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] f_wd(input logic [1:0] sz, input logic [1:0] lo, input logic [31:0] d);
    logic [31:0] r = 0;
    case (sz)
      2'b00: for (int i = 0; i < 8; i++) r[(3 - lo) * 8 + i] = d[i];
      2'b01: for (int i = 0; i < 16; i++) r[(lo == 0 ? 16 : 0) + i] = d[i];
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] f_ld(input logic [1:0] sz, input logic [1:0] lo, input logic u, input logic [31:0] w);
    logic [31:0] r = 0;
    case (sz)
      2'b00: begin
        for (int i = 0; i < 8; i++) r[i] = w[(3 - lo) * 8 + i];
        if (!u && r[7]) r[31:8] = '1;
      end
      2'b01: begin
        for (int i = 0; i < 16; i++) r[i] = w[(lo == 0 ? 16 : 0) + i];
        if (!u && r[15]) r[31:16] = '1;
      end
      default: r = w;
    endcase
    return r;
  endfunction

  task automatic run(input logic st, input logic [1:0] sz, input logic u,
                     input logic [31:0] b, input logic [15:0] o,
                     input logic [31:0] d, input logic [31:0] w);
    logic [31:0] ea;
    logic        bad;
    string       lt;
    ea  = f_ea(b, o);
    bad = f_bad(sz, ea[1:0]);
    lt  = (sz == 2'b00) ? "R5" : (sz == 2'b01) ? "R6" : (sz == 2'b11) ? "R10" : "R7";
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = sz; req_unsigned = u;
    base_addr = b; offset = o; st_data = d;
    @(negedge clk);
    req_valid = 0; mem_rdata = w;
    #1;
    chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    chk("R4 misalign", {31'b0, misalign}, {31'b0, bad});
    chk("R4 mem_req", {31'b0, mem_req}, {31'b0, !bad});
    chk("R2 byte_en", {28'b0, byte_en}, (st && !bad) ? {28'b0, f_be(sz, ea[1:0])} : 32'b0);
    if (st && !bad) chk("R3 wdata", mem_wdata, f_wd(sz, ea[1:0], d));
    if (!st && !bad) chk({lt, " ld_data"}, ld_data, f_ld(sz, ea[1:0], u, w));
    if (sz == 2'b11) chk("R10 word-like misalign", {31'b0, misalign}, {31'b0, ea[1:0] != 0});
    @(negedge clk);
    #1;
    chk("R8 idle mem_req", {31'b0, mem_req}, 32'b0);
    chk("R8 idle misalign", {31'b0, misalign}, 32'b0);
    chk("R8 idle byte_en", {28'b0, byte_en}, 32'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset mem_req", {31'b0, mem_req}, 32'b0);
    chk("R9 reset byte_en", {28'b0, byte_en}, 32'b0);
    chk("R9 reset misalign", {31'b0, misalign}, 32'b0);
    chk("R9 reset addr", mem_addr, 32'b0);
    chk("R9 reset wdata", mem_wdata, 32'b0);
    rst_n = 1;
    // directed corners
    for (int k = 0; k < 4; k++) run(1, 2'b00, 0, 32'h1000, 16'(k), 32'hFFFF_FFA5, 0);
    run(1, 2'b01, 0, 32'h2000, 16'h0000, 32'h1234_BEEF, 0);
    run(1, 2'b01, 0, 32'h2000, 16'h0002, 32'h1234_BEEF, 0);
    run(1, 2'b01, 0, 32'h2000, 16'h0001, 32'h1234_BEEF, 0);
    run(1, 2'b10, 0, 32'h3000, 16'h0002, 32'hCAFE_F00D, 0);
    run(1, 2'b10, 0, 32'h3000, 16'h0004, 32'hCAFE_F00D, 0);
    run(1, 2'b11, 0, 32'h3000, 16'h0003, 32'hCAFE_F00D, 0);
    run(0, 2'b00, 0, 32'h4000, 16'hFFFD, 0, 32'h0180_7F9C);
    run(0, 2'b00, 1, 32'h4000, 16'hFFFD, 0, 32'h0180_7F9C);
    run(0, 2'b01, 0, 32'h0000_0002, 16'h8000, 0, 32'h8001_7FFF);
    run(0, 2'b01, 1, 32'h0000_0000, 16'h0000, 0, 32'h8001_7FFF);
    run(0, 2'b10, 1, 32'h5000, 16'hFFFC, 0, 32'h8765_4321);
    run(0, 2'b11, 0, 32'h5000, 16'h0008, 0, 32'h8765_4321);
    run(0, 2'b00, 0, 32'hFFFF_FFFF, 16'h0001, 0, 32'h9A00_0000);
    // random traffic
    for (int i = 0; i < 400; i++)
      run(1'($urandom), 2'($urandom), 1'($urandom), $urandom, 16'($urandom), $urandom, $urandom);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule